// File: doc/BRIEF.md
# Teletype Line-Format Sequencer

This block sets the pace for a serial character framer that prints signed three-digit readings on a slow teletype link. It runs in the system clock domain. It counts bit ticks inside each 11-bit character and steps a character-select code through each word: a space, a sign, then the hundreds, tens and units digits. It also counts words on the current line. When a word ends, the block stops passing bit ticks downstream. It waits there until the data source signals that its next value is ready.

The tenth word of a line works differently. It does not stop after the units digit. The select code goes on to line feed, carriage return and a transmit-pause control character, so that word is eight characters long. The block then halts and the line count starts again at zero. A master reset clears everything and holds it cleared. A start-sync pulse then lets the sequencer run. The shift register that serializes the framed character sits outside this block. It is driven from `char_sel`, `load_en` and the gated tick `tick_out`.

Top module: `tty_line_seq`

## Requirements
- R1: While `rst` is high, and after reset until a start-sync pulse is seen, `char_sel` is 0, `load_en` is 0 and `tick_out` stays low whatever `bit_tick` does.
- R2: One clock after a `start_sync` pulse (with `rst` low), `bit_tick` pulses pass through to `tick_out`, and the first character of the line is the space (select 0).
- R3: A character takes 11 gated ticks. `char_sel` holds the character's code for ticks 1 to 10. The new code shows at tick 11, and `load_en` is high during tick 11 only.
- R4: In words 1 to 9 of a line, the select codes follow the order 0 (space), 1 (sign), 2 (hundreds), 3 (tens), 4 (units). After the units character the select code returns to 0.
- R5: When a word's last character finishes, `tick_out` stays low for as long as no rising edge of `ready` arrives. There is no timeout.
- R6: A `ready` pulse that arrives while characters are being sent has no effect. The word still halts at its normal end.
- R7: In the tenth word the select code goes on after 4 through 5 (line feed), 6 (carriage return) and 7 (transmit pause). The word is 88 ticks long and then halts.
- R8: After the tenth word the word count restarts at zero, so the next word is a normal five-character word.
- R9: Only a rising edge of `ready` ends a halt. A `ready` held high releases exactly one word.
- R10: Raising `rst` in the middle of a word brings the select code, the bit count and the word count back to zero. Running again needs a new `start_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous; clears the run state |
| start_sync | input | 1 | Pulse that lets the sequencer run after reset |
| bit_tick | input | 1 | One-clock strobe per serial bit period (110 per second on the line) |
| ready | input | 1 | Source reports that its next value is ready; acts on its rising edge |
| char_sel | output | 3 | Selects the character for the framer to load |
| load_en | output | 1 | Parallel-load enable for the framer, high during the last bit of a character |
| tick_out | output | 1 | Gated bit tick that clocks the framer's shift register |

## Verification
A wrong bit count shows up within one character: the select code changes on the wrong tick, or `load_en` lands away from tick 11. A wrong character or word count shows up at the end of the word it corrupts. Either an extra gated tick gets through where the block should halt, or a halt arrives early and the expected ticks never appear. A word counter that is off by one only shows when the line-feed tail turns up on the wrong word. That can take up to a full line of ten words. The bench therefore runs more than one full line, with resets and stray `ready` pulses placed in the middle.

// File: rtl/tty_seq_pkg.sv
`timescale 1ns/1ps
package tty_seq_pkg;
   // Character select codes understood by the framer
   localparam int SEL_SPACE = 0;
   localparam int SEL_SIGN  = 1;
   localparam int SEL_HUND  = 2;
   localparam int SEL_TENS  = 3;
   localparam int SEL_UNITS = 4;
   localparam int SEL_LF    = 5;
   localparam int SEL_CR    = 6;
   localparam int SEL_XOFF  = 7;

   // Bits needed to index n states (at least one)
   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tty_seq_bitcnt.sv
`timescale 1ns/1ps
module tty_seq_bitcnt #(
   parameter  int BITS_PER_CHAR = 11,
   localparam int BW = tty_seq_pkg::idx_width(BITS_PER_CHAR)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          tick,
   output logic [BW-1:0] bit_idx,
   output logic          sel_step,
   output logic          char_wrap
);
   localparam logic [BW-1:0] LAST_BIT = BW'(BITS_PER_CHAR - 1);
   localparam logic [BW-1:0] STEP_BIT = BW'(BITS_PER_CHAR - 2);

   always_ff @(posedge clk) begin
      if (clr)
         bit_idx <= '0;
      else if (tick)
         bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
   end

   assign sel_step  = (bit_idx == STEP_BIT);
   assign char_wrap = (bit_idx == LAST_BIT);
endmodule

// File: rtl/tty_seq_chars.sv
`timescale 1ns/1ps
module tty_seq_chars #(
   parameter  int CHARS_PER_WORD = 5,
   parameter  int TAIL_CHARS     = 3,
   parameter  int WORDS_PER_LINE = 10,
   localparam int SW = tty_seq_pkg::idx_width(CHARS_PER_WORD + TAIL_CHARS),
   localparam int WW = tty_seq_pkg::idx_width(WORDS_PER_LINE)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          tick,
   input  logic          sel_step,
   input  logic          char_wrap,
   output logic [SW-1:0] char_sel,
   output logic [WW-1:0] word_idx,
   output logic          word_done
);
   localparam logic [SW-1:0] SHORT_LAST = SW'(CHARS_PER_WORD - 1);
   localparam logic [SW-1:0] LONG_LAST  = SW'(CHARS_PER_WORD + TAIL_CHARS - 1);
   localparam logic [WW-1:0] LAST_WORD  = WW'(WORDS_PER_LINE - 1);

   logic [SW-1:0] done_cnt;
   logic [SW-1:0] last_sel;
   logic          last_word;

   assign last_word = (word_idx == LAST_WORD);

   generate
      if (TAIL_CHARS > 0) begin : g_tail
         assign last_sel = last_word ? LONG_LAST : SHORT_LAST;
      end else begin : g_no_tail
         logic unused_last;
         assign unused_last = last_word;
         assign last_sel    = SHORT_LAST;
      end
   endgenerate

   // select code moves one tick ahead of the character wrap
   always_ff @(posedge clk) begin
      if (clr)
         char_sel <= '0;
      else if (tick && sel_step)
         char_sel <= (char_sel == last_sel) ? '0 : char_sel + 1'b1;
   end

   // characters completed in the current word, and words on the line
   always_ff @(posedge clk) begin
      if (clr) begin
         done_cnt <= '0;
         word_idx <= '0;
      end else if (tick && char_wrap) begin
         if (done_cnt == last_sel) begin
            done_cnt <= '0;
            word_idx <= last_word ? '0 : word_idx + 1'b1;
         end else begin
            done_cnt <= done_cnt + 1'b1;
         end
      end
   end

   assign word_done = tick && char_wrap && (done_cnt == last_sel);
endmodule

// File: rtl/tty_seq_gate.sv
`timescale 1ns/1ps
module tty_seq_gate #(
   parameter bit READY_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic start_sync,
   input  logic ready,
   input  logic bit_tick,
   input  logic word_done,
   output logic running,
   output logic halted,
   output logic tick_out
);
   logic ready_ev;

   generate
      if (READY_EDGE) begin : g_edge
         logic ready_q;
         always_ff @(posedge clk) begin
            if (rst) ready_q <= 1'b0;
            else     ready_q <= ready;
         end
         assign ready_ev = ready && !ready_q;
      end else begin : g_level
         assign ready_ev = ready;
      end
   endgenerate

   // set/reset run latch: reset wins, start sync sets
   always_ff @(posedge clk) begin
      if (rst)             running <= 1'b0;
      else if (start_sync) running <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || !running)
         halted <= 1'b0;
      else if (word_done)
         halted <= 1'b1;
      else if (halted && ready_ev)
         halted <= 1'b0;
   end

   assign tick_out = bit_tick && running && !halted;
endmodule

// File: rtl/tty_line_seq.sv
`timescale 1ns/1ps
module tty_line_seq #(
   parameter  int BITS_PER_CHAR  = 11,
   parameter  int CHARS_PER_WORD = 5,
   parameter  int TAIL_CHARS     = 3,
   parameter  int WORDS_PER_LINE = 10,
   parameter  bit READY_EDGE     = 1'b1,
   localparam int SEL_W = tty_seq_pkg::idx_width(CHARS_PER_WORD + TAIL_CHARS),
   localparam int BIT_W = tty_seq_pkg::idx_width(BITS_PER_CHAR),
   localparam int WORD_W = tty_seq_pkg::idx_width(WORDS_PER_LINE)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_sync,
   input  logic             bit_tick,
   input  logic             ready,
   output logic [SEL_W-1:0] char_sel,
   output logic             load_en,
   output logic             tick_out
);
   generate
      if (BITS_PER_CHAR < 3) begin : g_bad_bits
         $error("BITS_PER_CHAR must be at least 3");
      end
      if (CHARS_PER_WORD < 2) begin : g_bad_chars
         $error("CHARS_PER_WORD must be at least 2");
      end
      if (WORDS_PER_LINE < 2) begin : g_bad_words
         $error("WORDS_PER_LINE must be at least 2");
      end
      if (TAIL_CHARS < 0) begin : g_bad_tail
         $error("TAIL_CHARS must not be negative");
      end
   endgenerate

   logic              running;
   logic              halted;
   logic              clr;
   logic              sel_step;
   logic              char_wrap;
   logic              word_done;
   logic [BIT_W-1:0]  bit_idx;
   logic [WORD_W-1:0] word_idx;

   assign clr = rst || !running;

   tty_seq_gate #(.READY_EDGE(READY_EDGE)) u_gate (
      .clk       (clk),
      .rst       (rst),
      .start_sync(start_sync),
      .ready     (ready),
      .bit_tick  (bit_tick),
      .word_done (word_done),
      .running   (running),
      .halted    (halted),
      .tick_out  (tick_out)
   );

   tty_seq_bitcnt #(.BITS_PER_CHAR(BITS_PER_CHAR)) u_bits (
      .clk      (clk),
      .clr      (clr),
      .tick     (tick_out),
      .bit_idx  (bit_idx),
      .sel_step (sel_step),
      .char_wrap(char_wrap)
   );

   tty_seq_chars #(
      .CHARS_PER_WORD(CHARS_PER_WORD),
      .TAIL_CHARS    (TAIL_CHARS),
      .WORDS_PER_LINE(WORDS_PER_LINE)
   ) u_chars (
      .clk      (clk),
      .clr      (clr),
      .tick     (tick_out),
      .sel_step (sel_step),
      .char_wrap(char_wrap),
      .char_sel (char_sel),
      .word_idx (word_idx),
      .word_done(word_done)
   );

   assign load_en = running && char_wrap;
endmodule

// File: rtl/tty_line_seq_chk.sv
`timescale 1ns/1ps
module tty_line_seq_chk #(
   parameter int BITS_PER_CHAR  = 11,
   parameter int CHARS_PER_WORD = 5,
   parameter int WORDS_PER_LINE = 10,
   parameter int SEL_W  = 3,
   parameter int BIT_W  = 4,
   parameter int WORD_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              ready,
   input logic              running,
   input logic              halted,
   input logic              tick_out,
   input logic              load_en,
   input logic [SEL_W-1:0]  char_sel,
   input logic [BIT_W-1:0]  bit_idx,
   input logic [WORD_W-1:0] word_idx
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (char_sel == '0 && !load_en && !tick_out));

   assert_no_tick_stopped_R1: assert property (@(posedge clk) disable iff (rst)
      !running |-> !tick_out);

   assert_bit_range_R3: assert property (@(posedge clk) disable iff (rst)
      int'(bit_idx) < BITS_PER_CHAR);

   assert_load_moves_sel_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(load_en) |-> !$stable(char_sel));

   assert_tail_last_word_R7: assert property (@(posedge clk) disable iff (rst)
      (int'(char_sel) >= CHARS_PER_WORD) |-> (int'(word_idx) == WORDS_PER_LINE - 1));

   assert_halt_gates_R5: assert property (@(posedge clk) disable iff (rst)
      halted |-> !tick_out);

   assert_halt_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(halted) |-> (char_sel == '0 && bit_idx == '0));

   assert_resume_by_ready_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(halted) |-> ($past(ready) || $past(rst)));
endmodule

bind tty_line_seq tty_line_seq_chk #(
   .BITS_PER_CHAR (BITS_PER_CHAR),
   .CHARS_PER_WORD(CHARS_PER_WORD),
   .WORDS_PER_LINE(WORDS_PER_LINE),
   .SEL_W         (SEL_W),
   .BIT_W         (BIT_W),
   .WORD_W        (WORD_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .ready   (ready),
   .running (running),
   .halted  (halted),
   .tick_out(tick_out),
   .load_en (load_en),
   .char_sel(char_sel),
   .bit_idx (bit_idx),
   .word_idx(word_idx)
);

// File: tb/tb_tty_line_seq.sv
`timescale 1ns/1ps
module tb_tty_line_seq;
   localparam int BPC = 11;
   localparam int CPW = 5;
   localparam int TAIL = 3;
   localparam int WPL = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_sync = 1'b0;
   logic bit_tick = 1'b0;
   logic ready = 1'b0;
   logic [2:0] char_sel;
   logic load_en;
   logic tick_out;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   tty_line_seq dut (
      .clk       (clk),
      .rst       (rst),
      .start_sync(start_sync),
      .bit_tick  (bit_tick),
      .ready     (ready),
      .char_sel  (char_sel),
      .load_en   (load_en),
      .tick_out  (tick_out)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: every gated tick must match the next expected {load_en, char_sel}
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (tick_out === 1'b1) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 gated tick while halted", 1, 0);
            end else begin
               logic [3:0] e;
               logic [3:0] a;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               a = {load_en, char_sel};
               check(a === e, t, int'(a), int'(e));
            end
         end
      end
   end

   // driver side: expected tick items for one word
   task automatic push_word(input bit tenth, input string wtag);
      int n;
      n = tenth ? CPW + TAIL : CPW;
      for (int c = 0; c < n; c++) begin
         for (int b = 1; b <= BPC; b++) begin
            if (b < BPC) begin
               exp_q.push_back({1'b0, 3'(c)});
               tag_q.push_back(wtag);
            end else begin
               exp_q.push_back({1'b1, 3'((c == n - 1) ? 0 : c + 1)});
               tag_q.push_back("R3 load tick");
            end
         end
      end
   endtask

   task automatic tick();
      @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_ready();
      @(negedge clk);
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
   endtask

   task automatic blocked_ticks(input string htag);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         bit_tick = 1'b1;
         #1;
         check(tick_out == 1'b0, htag, int'(tick_out), 0);
         @(negedge clk);
         bit_tick = 1'b0;
      end
   endtask

   task automatic run_word(input bit tenth, input string wtag, input int ready_at, input string htag);
      int n;
      n = (tenth ? CPW + TAIL : CPW) * BPC;
      push_word(tenth, wtag);
      for (int i = 1; i <= n; i++) begin
         if (i == ready_at) pulse_ready();
         tick();
      end
      check(exp_q.size() == 0, {wtag, " all ticks of word seen"}, exp_q.size(), 0);
      blocked_ticks(htag);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(char_sel == 3'd0, "R1 select in reset", int'(char_sel), 0);
      check(load_en == 1'b0, "R1 load in reset", int'(load_en), 0);
      bit_tick = 1'b1;
      #1;
      check(tick_out == 1'b0, "R1 tick blocked in reset", int'(tick_out), 0);
      @(negedge clk);
      bit_tick = 1'b0;
      rst = 1'b0;
      repeat (2) @(negedge clk);
      bit_tick = 1'b1;
      #1;
      check(tick_out == 1'b0, "R1 tick blocked before start", int'(tick_out), 0);
      @(negedge clk);
      bit_tick = 1'b0;

      // R2: start sync lets the line run
      start_sync = 1'b1;
      @(negedge clk);
      start_sync = 1'b0;
      @(negedge clk);
      check(char_sel == 3'd0, "R2 first select is space", int'(char_sel), 0);

      // full line; stray ready mid-word 3 (R6)
      for (int w = 0; w < WPL; w++) begin
         if (w == WPL - 1)
            run_word(1'b1, "R7 tail word", 0, "R7 halt after tail");
         else if (w == 2)
            run_word(1'b0, "R4 word order", 20, "R6 stray ready ignored");
         else
            run_word(1'b0, "R4 word order", 0, "R5 halt after word");
         pulse_ready();
      end

      // R8: next line starts with a normal word
      run_word(1'b0, "R8 word after line", 0, "R8 halt after word");

      // R9: ready held high releases one word only
      @(negedge clk);
      ready = 1'b1;
      run_word(1'b0, "R9 word under held ready", 0, "R9 held ready no second release");
      @(negedge clk);
      ready = 1'b0;
      pulse_ready();

      // R10: reset in the middle of a word (line position is word 2 here)
      push_word(1'b0, "R10 partial word");
      for (int i = 0; i < 17; i++) tick();
      exp_q.delete();
      tag_q.delete();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(char_sel == 3'd0, "R10 select cleared", int'(char_sel), 0);
      check(load_en == 1'b0, "R10 load cleared", int'(load_en), 0);
      rst = 1'b0;
      @(negedge clk);
      bit_tick = 1'b1;
      #1;
      check(tick_out == 1'b0, "R10 needs new start", int'(tick_out), 0);
      @(negedge clk);
      bit_tick = 1'b0;
      start_sync = 1'b1;
      @(negedge clk);
      start_sync = 1'b0;
      for (int w = 0; w < WPL; w++) begin
         if (w == WPL - 1)
            run_word(1'b1, "R10 tail after full recount", 0, "R10 halt after tail");
         else
            run_word(1'b0, "R10 word count restarted", 0, "R10 halt after word");
         pulse_ready();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule